// File: doc/BRIEF.md
# Three-Stage Program Counter Chain

This block holds the three linked instruction addresses of a CPU with delayed branches. The lookahead address names the instruction being fetched for the following cycle. The current address names the instruction now executing. The previous address names the instruction that executed just before it. The lookahead address also drives the fetch port.

Every cycle in which the advance strobe is high, the chain moves forward. The current address moves into the previous slot, and the lookahead address moves into the current slot. The new lookahead address is then chosen from three sources. The default is the old lookahead plus one instruction size. A branch request supplies its target instead. An interrupt request loads a vector.

Because a branch target only reaches the lookahead slot, the instruction that follows a branch always executes. That instruction is the delay slot. When an interrupt is taken, the previous slot keeps the address of the aborted instruction so that it can be restarted. The block does no instruction decode and has no memory.

Top module: `pc_chain`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the previous, current and lookahead addresses are all zero.
- R2: While `advance` is low, all three addresses keep their values, whatever `brReq` and `irqReq` are.
- R3: On an advance with neither request, the previous address takes the current address and the current address takes the lookahead address. The lookahead address increases by 4.
- R4: On an advance with `brReq` high and `irqReq` low, the previous address takes the current address and the current address takes the old lookahead address. The lookahead address takes `brTarget`, so exactly one delay-slot instruction runs first.
- R5: On an advance with `irqReq` high, the previous address takes the current address, which is the aborted instruction. The current address takes `irqVector` and the lookahead address takes `irqVector` + 4.
- R6: When `brReq` and `irqReq` are both high on an advance, the interrupt behaviour of R5 applies and `brTarget` is ignored.
- R7: `fetchAddr` always equals the lookahead address.
- R8: Address arithmetic wraps modulo 2^32, so a sequential step from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Moves the chain forward when high |
| brReq | input | 1 | Take a branch on this advance |
| brTarget | input | 32 | Branch target address |
| irqReq | input | 1 | Take an interrupt on this advance |
| irqVector | input | 32 | Interrupt handler address |
| lastPc | output | 32 | Previous address (restart address after an interrupt) |
| curPc | output | 32 | Address of the instruction now executing |
| nextPc | output | 32 | Lookahead address |
| fetchAddr | output | 32 | Address presented to instruction fetch |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 4-byte instruction size and a reset address of zero. With the full 32-bit width, a branch to 0xFFFFFFF8 followed by two sequential steps reaches the modulo wrap of R8. The bench holds both requests high while `advance` is low to show the stall. It also raises branch and interrupt together to show interrupt priority. It follows a branch with plain steps so that the delay slot appears at the current address output.

// File: rtl/pc_chain_pkg.sv
package pc_chain_pkg;

  // Source select for the lookahead register.
  typedef enum logic [1:0] {
    NX_HOLD   = 2'd0,
    NX_STEP   = 2'd1,
    NX_TARGET = 2'd2,
    NX_VECTOR = 2'd3
  } nextSelT;

  // Source select for the current register.
  typedef enum logic [0:0] {
    PC_FROM_NEXT   = 1'b0,
    PC_FROM_VECTOR = 1'b1
  } pcSelT;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic    shiftEn;
    pcSelT   pcSel;
    nextSelT nextSel;
  } pcCtrlT;

endpackage

// File: rtl/pc_chain_ctrl.sv
module pc_chain_ctrl
  import pc_chain_pkg::*;
(
  input  logic   advance,
  input  logic   brReq,
  input  logic   irqReq,
  output pcCtrlT ctrl
);

  // Priority: an interrupt beats a branch, and a branch beats a plain step.
  always_comb begin
    ctrl.shiftEn = advance;
    ctrl.pcSel   = PC_FROM_NEXT;
    ctrl.nextSel = NX_HOLD;
    if (advance) begin
      if (irqReq) begin
        ctrl.pcSel   = PC_FROM_VECTOR;
        ctrl.nextSel = NX_VECTOR;
      end else if (brReq) begin
        ctrl.nextSel = NX_TARGET;
      end else begin
        ctrl.nextSel = NX_STEP;
      end
    end
  end

endmodule

// File: rtl/pc_chain_dp.sv
module pc_chain_dp
  import pc_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  pcCtrlT            ctrl,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [ADDR_W-1:0] irqVector,
  output logic [ADDR_W-1:0] lastPc,
  output logic [ADDR_W-1:0] curPc,
  output logic [ADDR_W-1:0] nextPc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] lastQ, curQ, nextQ;
  logic [ADDR_W-1:0] curD, nextD;

  always_comb begin
    curD = (ctrl.pcSel == PC_FROM_VECTOR) ? irqVector : nextQ;
    unique case (ctrl.nextSel)
      NX_STEP:   nextD = nextQ + STEP;
      NX_TARGET: nextD = brTarget;
      NX_VECTOR: nextD = irqVector + STEP;
      default:   nextD = nextQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastQ <= RESET_ADDR;
      curQ  <= RESET_ADDR;
      nextQ <= RESET_ADDR;
    end else if (ctrl.shiftEn) begin
      lastQ <= curQ;
      curQ  <= curD;
      nextQ <= nextD;
    end
  end

  assign lastPc = lastQ;
  assign curPc  = curQ;
  assign nextPc = nextQ;

endmodule

// File: rtl/pc_chain.sv
module pc_chain
  import pc_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              brReq,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              irqReq,
  input  logic [ADDR_W-1:0] irqVector,
  output logic [ADDR_W-1:0] lastPc,
  output logic [ADDR_W-1:0] curPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] fetchAddr
);

  pcCtrlT ctrl;

  pc_chain_ctrl u_ctrl (
    .advance (advance),
    .brReq   (brReq),
    .irqReq  (irqReq),
    .ctrl    (ctrl)
  );

  pc_chain_dp #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_ADDR (RESET_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .brTarget  (brTarget),
    .irqVector (irqVector),
    .lastPc    (lastPc),
    .curPc     (curPc),
    .nextPc    (nextPc)
  );

  // Fetch reads from the lookahead slot (R7).
  assign fetchAddr = nextPc;

endmodule

// File: rtl/pc_chain_chk.sv
module pc_chain_chk #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic              brReq,
  input logic [ADDR_W-1:0] brTarget,
  input logic              irqReq,
  input logic [ADDR_W-1:0] irqVector,
  input logic [ADDR_W-1:0] lastPc,
  input logic [ADDR_W-1:0] curPc,
  input logic [ADDR_W-1:0] nextPc,
  input logic [ADDR_W-1:0] fetchAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (lastPc == '0 && curPc == '0 && nextPc == '0));

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(lastPc) && $stable(curPc) && $stable(nextPc)));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !brReq && !irqReq) |=>
      (lastPc == $past(curPc) && curPc == $past(nextPc) && nextPc == $past(nextPc) + STEP));

  p_branch_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && brReq && !irqReq) |=>
      (lastPc == $past(curPc) && curPc == $past(nextPc) && nextPc == $past(brTarget)));

  p_irq_vector_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && irqReq) |=>
      (lastPc == $past(curPc) && curPc == $past(irqVector) && nextPc == $past(irqVector) + STEP));

  p_irq_beats_branch_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && irqReq && brReq) |=> (curPc == $past(irqVector)));

  p_fetch_port_r7: assert property (@(posedge clk) disable iff (rst)
    advance |=> (fetchAddr == nextPc));

endmodule

bind pc_chain pc_chain_chk #(
  .ADDR_W     (ADDR_W),
  .INSN_BYTES (INSN_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .advance   (advance),
  .brReq     (brReq),
  .brTarget  (brTarget),
  .irqReq    (irqReq),
  .irqVector (irqVector),
  .lastPc    (lastPc),
  .curPc     (curPc),
  .nextPc    (nextPc),
  .fetchAddr (fetchAddr)
);

// File: tb/sim_pc_chain.sv
`timescale 1ns/1ps
module sim_pc_chain;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic        brReq = 1'b0;
  logic [31:0] brTarget = '0;
  logic        irqReq = 1'b0;
  logic [31:0] irqVector = '0;
  logic [31:0] lastPc, curPc, nextPc, fetchAddr;

  int total = 0;
  int bad = 0;
  logic [31:0] eLast, eCur, eNext;

  always #4 clk = ~clk;

  pc_chain u0 (
    .clk(clk), .rst(rst), .advance(advance), .brReq(brReq), .brTarget(brTarget),
    .irqReq(irqReq), .irqVector(irqVector), .lastPc(lastPc), .curPc(curPc),
    .nextPc(nextPc), .fetchAddr(fetchAddr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "lastPc", lastPc, eLast);
    check(tag, "curPc", curPc, eCur);
    check(tag, "nextPc", nextPc, eNext);
    check("R7", "fetchAddr", fetchAddr, eNext);
  endtask

  // Drive one cycle, update the expected model from the requirements, then compare.
  task automatic cycle(input string tag, input logic adv, input logic br, input logic [31:0] tgt,
                       input logic irq, input logic [31:0] vec);
    @(negedge clk);
    advance = adv; brReq = br; brTarget = tgt; irqReq = irq; irqVector = vec;
    @(posedge clk);
    #1;
    if (adv) begin
      eLast = eCur;
      if (irq) begin
        eCur = vec; eNext = vec + 32'd4;
      end else if (br) begin
        eCur = eNext; eNext = tgt;
      end else begin
        eCur = eNext; eNext = eNext + 32'd4;
      end
    end
    checkAll(tag);
  endtask

  task automatic tReset;
    @(negedge clk);
    rst = 1'b1; advance = 1'b0; brReq = 1'b0; irqReq = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    eLast = '0; eCur = '0; eNext = '0;
    checkAll("R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    checkAll("R1");
  endtask

  task automatic tSequential;
    for (int i = 0; i < 3; i++) cycle("R3", 1'b1, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic tStall;
    cycle("R2", 1'b0, 1'b1, 32'h0000_8000, 1'b1, 32'h0000_0100);
    cycle("R2", 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic tBranchSlot;
    logic [31:0] slot;
    slot = eNext;
    cycle("R4", 1'b1, 1'b1, 32'h0000_2000, 1'b0, 32'h0);
    check("R4", "delay slot", curPc, slot);
    cycle("R4", 1'b1, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R4", "target executes", curPc, 32'h0000_2000);
  endtask

  task automatic tInterrupt;
    logic [31:0] aborted;
    aborted = eCur;
    cycle("R5", 1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_0040);
    check("R5", "aborted kept", lastPc, aborted);
    cycle("R5", 1'b1, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic tPriority;
    cycle("R6", 1'b1, 1'b1, 32'h0000_9000, 1'b1, 32'h0000_0080);
    check("R6", "target ignored", nextPc, 32'h0000_0084);
  endtask

  task automatic tWrap;
    cycle("R8", 1'b1, 1'b1, 32'hFFFF_FFF8, 1'b0, 32'h0);
    cycle("R8", 1'b1, 1'b0, 32'h0, 1'b0, 32'h0);
    cycle("R8", 1'b1, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R8", "wrap to zero", nextPc, 32'h0000_0000);
  endtask

  initial begin
    tReset();
    tSequential();
    tStall();
    tBranchSlot();
    tInterrupt();
    tPriority();
    tWrap();
    tReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule